// File: doc/BRIEF.md
# 8-bit Timer with Compare Output

This block is an 8-bit counter that advances on enable ticks taken from a free-running 10-bit prescaler. It compares the count against an 8-bit compare register. On a match it sets an interrupt flag and drives one output pin according to a 2-bit action field. It can also clear the count on a match. A PWM mode reuses the same counter, either as an up/down counter or as a counter that wraps from 0xFF to 0x00.

Software reaches four registers through a simple synchronous write port and a combinational read port:

| Address | Register |
|---|---|
| 0 | control |
| 1 | count |
| 2 | compare value |
| 3 | flag |

The control byte has these fields:

| Bits | Field |
|---|---|
| 7 | force strobe (write only) |
| 6 | PWM select |
| 5:4 | action field |
| 3 | clear/style bit |
| 2:0 | tick source |

A force strobe applies the pin action at once, without waiting for a match. The pin driver is enabled only while an external direction input is high.

Top module: `timer8_cmp`

## Requirements
- R1: After reset every register reads 0, the pin level is 0, the flag is 0 and cmp_oe is 0.
- R2: Tick source 000 stops the count. Codes 001 to 111 advance it once every 1, 8, 32, 64, 128, 256 and 1024 clocks, taken from a free-running 10-bit prescaler.
- R3: Outside PWM with bit 3 set, a tick while count equals compare value C loads 0. The count runs ..., C-1, C, 0, 1, ..., and each value, C included, lasts one full tick period.
- R4: Outside PWM with bit 3 clear, the count passes the compare value and wraps from 0xFF to 0x00.
- R5: Outside PWM, the action field selects what a match or force does to the pin: 00 leaves it alone, 01 inverts it, 10 drives it to 0 and 11 drives it to 1.
- R6: cmp_oe is high only when dir_en is high and the action field is not 00. cmp_out always shows the pin level.
- R7: The flag (address 3, bit 0) is set by a tick on which count equals compare. Writing 1 to bit 0 clears it; writing 0 leaves it.
- R8: A control write with bit 7 set applies the pin action but sets no flag and never clears the count. Bit 7 reads back as 0.
- R9: A force is ignored when the same control write sets bit 6 (PWM).
- R10: A force uses the action field held before its own write. A new field written with it takes effect from the next match or force.
- R11: In PWM with bit 3 clear, the count rises to 0xFF, turns to 0xFE and falls, then turns at 0x00 to 0x01.
- R12: In up/down PWM, action 10 drives the pin to 0 on an upward match and to 1 on a downward match. Action 11 does the opposite.
- R13: In PWM with bit 3 set, the count wraps 0xFF to 0x00 without clearing on a match. Action 10 drives the pin to 1 at the wrap and to 0 on a match; action 11 inverts both.
- R14: A write to the count register loads it in that cycle, taking priority over a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 count, 2 compare, 3 flag) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 8 | Read data, combinational |
| dir_en | input | 1 | External pin direction enable |
| cmp_out | output | 1 | Pin level |
| cmp_oe | output | 1 | Pin output enable |
| irq_flag | output | 1 | Compare-match flag |

## Verification
A force strobe and a real compare match can land on the same clock edge. The bench provokes this by loading the count with the compare value while the timer ticks every clock, then issuing the force write on the very next cycle. The toggle action must be applied only once. The flag must still be set by the real match, and the count must still clear because clear-on-match is enabled.

// File: rtl/timer8_cmp.sv
module timer8_cmp #(
  parameter int PSC_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       dir_en,
  output logic       cmp_out,
  output logic       cmp_oe,
  output logic       irq_flag
);
  localparam logic [7:0] TOP = 8'hFF;

  logic [6:0]       ctrl_q;
  logic [7:0]       cnt_q, ocr_q;
  logic [PSC_W-1:0] psc_q, msk;
  logic             up_q, pin_q, flag_q, pin_nxt;

  wire       pwm  = ctrl_q[6];
  wire [1:0] mode = ctrl_q[5:4];
  wire       clr  = ctrl_q[3];
  wire [2:0] cs   = ctrl_q[2:0];

  wire wr_ctrl  = wr_en && wr_addr == 2'd0;
  wire wr_cnt   = wr_en && wr_addr == 2'd1;
  wire wr_ocr   = wr_en && wr_addr == 2'd2;
  wire wr_flag  = wr_en && wr_addr == 2'd3;
  wire force_go = wr_ctrl && wr_data[7] && !wr_data[6];

  always_comb begin
    case (cs)
      3'd2:    msk = PSC_W'(7);
      3'd3:    msk = PSC_W'(31);
      3'd4:    msk = PSC_W'(63);
      3'd5:    msk = PSC_W'(127);
      3'd6:    msk = PSC_W'(255);
      3'd7:    msk = PSC_W'(1023);
      default: msk = '0;
    endcase
  end

  wire tick    = (cs != 3'd0) && ((psc_q & msk) == msk);
  wire hit     = tick && (cnt_q == ocr_q);
  wire wrap_ev = pwm && clr && tick && (cnt_q == TOP);

  always_comb begin
    pin_nxt = pin_q;
    if (!pwm) begin
      if (hit || force_go)
        case (mode)
          2'b01:   pin_nxt = !pin_q;
          2'b10:   pin_nxt = 1'b0;
          2'b11:   pin_nxt = 1'b1;
          default: pin_nxt = pin_q;
        endcase
    end else if (mode[1]) begin
      if (hit)
        pin_nxt = (clr ? 1'b0 : !up_q) ^ mode[0];
      else if (wrap_ev)
        pin_nxt = !mode[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      ocr_q  <= '0;
      psc_q  <= '0;
      up_q   <= 1'b1;
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      psc_q <= psc_q + 1'b1;
      pin_q <= pin_nxt;
      if (wr_ctrl) ctrl_q <= wr_data[6:0];
      if (wr_ocr)  ocr_q  <= wr_data;
      if (hit)
        flag_q <= 1'b1;
      else if (wr_flag && wr_data[0])
        flag_q <= 1'b0;
      if (wr_cnt)
        cnt_q <= wr_data;
      else if (tick) begin
        if (!pwm)
          cnt_q <= (hit && clr) ? 8'd0 : cnt_q + 8'd1;
        else if (clr)
          cnt_q <= cnt_q + 8'd1;
        else if (up_q) begin
          if (cnt_q == TOP) begin
            cnt_q <= TOP - 8'd1;
            up_q  <= 1'b0;
          end else
            cnt_q <= cnt_q + 8'd1;
        end else begin
          if (cnt_q == 8'd0) begin
            cnt_q <= 8'd1;
            up_q  <= 1'b1;
          end else
            cnt_q <= cnt_q - 8'd1;
        end
      end
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {1'b0, ctrl_q};
      2'd1:    rd_data = cnt_q;
      2'd2:    rd_data = ocr_q;
      default: rd_data = {7'd0, flag_q};
    endcase
  end

  assign cmp_out  = pin_q;
  assign cmp_oe   = dir_en && (mode != 2'b00);
  assign irq_flag = flag_q;

  AST_FLAG_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(hit)); // R7
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && wr_data[0] && !hit) |=> !flag_q); // R7
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs == 3'd0 && !wr_cnt) |=> $stable(cnt_q)); // R2
  AST_CLEAR_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr && !pwm && !wr_cnt) |=> cnt_q == 8'd0); // R3
  AST_FORCE_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (force_go && !tick && !wr_cnt) |=> $stable(cnt_q)); // R8
  AST_TURN_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !clr && tick && up_q && cnt_q == TOP && !wr_cnt) |=> cnt_q == TOP - 8'd1); // R11
endmodule

// File: tb/timer8_cmp_test.sv
module timer8_cmp_test;
  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, dir_en = 1'b1;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic       cmp_out, cmp_oe, irq_flag;
  int errors = 0, checks = 0;
  bit done = 0;

  timer8_cmp uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .dir_en(dir_en),
    .cmp_out(cmp_out), .cmp_oe(cmp_oe), .irq_flag(irq_flag));

  always #5 clk = !clk;

  // {mode[1:0], start level, expected level} for non-PWM force actions (R5)
  localparam logic [3:0] VEC [8] = '{
    4'b0000, 4'b0011, 4'b0101, 4'b0110,
    4'b1000, 4'b1010, 4'b1101, 4'b1111 };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic set_pin(input logic lvl);
    wr(0, {2'b00, lvl ? 2'b11 : 2'b10, 4'b0000});
    wr(0, {2'b10, lvl ? 2'b11 : 2'b10, 4'b0000});
  endtask

  task automatic period(input logic [2:0] cs, input int exp, input string req);
    int v0, v, n;
    wr(0, 8'h00); wr(2, 8'hFF); wr(1, 8'd0);
    wr(0, {5'b00000, cs});
    rd(1, v0);
    for (int i = 0; i < 3000 && v == v0; i++) begin @(negedge clk); rd(1, v); end
    v0 = v; n = 0;
    while (v == v0 && n < 3000) begin @(negedge clk); rd(1, v); n++; end
    chk(req, n, exp);
  endtask

  initial begin
    int v, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(a[1:0], v); chk("R1 reg", v, 0); end
    chk("R1 pin", cmp_out, 0); chk("R1 oe", cmp_oe, 0); chk("R1 flag", irq_flag, 0);

    // R5 action table, R6 enable
    foreach (VEC[i]) begin
      set_pin(VEC[i][1]);
      wr(0, {2'b00, VEC[i][3:2], 4'b0000});
      wr(0, {2'b10, VEC[i][3:2], 4'b0000});
      chk("R5 action", cmp_out, VEC[i][0]);
      chk("R6 oe", cmp_oe, VEC[i][3:2] != 2'b00);
    end
    dir_en = 1'b0; #1; chk("R6 dir low", cmp_oe, 0); dir_en = 1'b1;
    chk("R7 no flag from force", irq_flag, 0);

    // R2 prescaler periods
    period(3'd1, 1, "R2 div1"); period(3'd2, 8, "R2 div8");
    period(3'd3, 32, "R2 div32"); period(3'd4, 64, "R2 div64");
    period(3'd7, 1024, "R2 div1024");
    wr(0, 8'h00); rd(1, p0); repeat (20) @(negedge clk); rd(1, v);
    chk("R2 stopped", v, p0);

    // R3 / R14 clear on match, every clock
    wr(2, 8'd5); wr(0, 8'b0000_1001); wr(3, 8'h01);
    wr(1, 8'd3); rd(1, v); chk("R14 load wins", v, 3);
    @(negedge clk); rd(1, v); chk("R3 C-1", v, 4);
    @(negedge clk); rd(1, v); chk("R3 C", v, 5);
    @(negedge clk); rd(1, v); chk("R3 zero", v, 0); chk("R7 flag set", irq_flag, 1);
    @(negedge clk); rd(1, v); chk("R3 one", v, 1);
    wr(3, 8'h00); chk("R7 write0 keeps", irq_flag, 1);
    wr(0, 8'h00); wr(3, 8'h01); chk("R7 write1 clears", irq_flag, 0);

    // R3 with divide by 8
    wr(2, 8'd10); wr(1, 8'd9); wr(0, 8'b0000_1010);
    v = 9; while (v == 9) begin @(negedge clk); rd(1, v); end
    chk("R3 reach C", v, 10);
    p0 = 0; while (v == 10 && p0 < 100) begin @(negedge clk); rd(1, v); p0++; end
    chk("R3 C held", p0, 8); chk("R3 then 0", v, 0);
    p0 = 0; while (v == 0 && p0 < 100) begin @(negedge clk); rd(1, v); p0++; end
    chk("R3 0 held", p0, 8);

    // R4 no clear, wraps
    wr(0, 8'h00); wr(2, 8'd5); wr(1, 8'd4); wr(0, 8'b0000_0001);
    @(negedge clk); rd(1, v); chk("R4 at C", v, 5);
    @(negedge clk); rd(1, v); chk("R4 past C", v, 6);
    wr(0, 8'h00); wr(1, 8'd254); wr(0, 8'b0000_0001);
    @(negedge clk); rd(1, v); chk("R4 FF", v, 255);
    @(negedge clk); rd(1, v); chk("R4 wrap", v, 0);
    wr(0, 8'h00); wr(3, 8'h01);

    // R8 force: no flag, no clear, reads 0
    wr(2, 8'd7); wr(1, 8'd7); set_pin(1'b0);
    wr(0, 8'b0001_1000); wr(0, 8'b1001_1000);
    chk("R8 toggled", cmp_out, 1); chk("R8 no flag", irq_flag, 0);
    rd(1, v); chk("R8 no clear", v, 7);
    rd(0, v); chk("R8 reads 0", v, 8'b0001_1000);
    // R9 force ignored with PWM set
    wr(0, 8'b1101_0000); chk("R9 ignored", cmp_out, 1);
    // R10 deferred mode
    wr(0, 8'b0010_0000); chk("R10 setup", cmp_out, 1);
    wr(0, 8'b1011_0000); chk("R10 old mode used", cmp_out, 0);
    wr(2, 8'd3); wr(1, 8'd2); wr(0, 8'b0011_0001);
    repeat (3) @(negedge clk);
    chk("R10 new mode on match", cmp_out, 1); chk("R7 flag", irq_flag, 1);
    wr(0, 8'h00); wr(3, 8'h01);

    // Force and real match on the same edge
    wr(2, 8'd4); wr(0, 8'b0001_1001);
    p0 = cmp_out;
    wr(1, 8'd4); wr(0, 8'b1001_1001);
    chk("R8 single toggle", cmp_out, !p0); chk("R7 flag on coincident", irq_flag, 1);
    rd(1, v); chk("R3 clear on coincident", v, 0);
    wr(0, 8'h00); wr(3, 8'h01);

    // R11 / R12 up/down PWM, mode 10
    set_pin(1'b1);
    wr(2, 8'd254); wr(1, 8'd252); wr(0, 8'b0110_0001);
    begin
      int ec [6] = '{253, 254, 255, 254, 253, 252};
      int ep [6] = '{1, 1, 0, 0, 1, 1};
      for (int i = 0; i < 6; i++) begin
        @(negedge clk); rd(1, v);
        chk("R11 updown count", v, ec[i]); chk("R12 mode10 pin", cmp_out, ep[i]);
      end
    end
    wr(0, 8'b0110_0000); wr(2, 8'd250); wr(1, 8'd251); wr(0, 8'b0111_0001);
    @(negedge clk); chk("R12 mode11 before", cmp_out, 1);
    @(negedge clk); chk("R12 mode11 down clears", cmp_out, 0);
    wr(0, 8'b0111_0000); wr(1, 8'd1); wr(0, 8'b0111_0001);
    @(negedge clk); rd(1, v); chk("R11 reach 0", v, 0);
    @(negedge clk); rd(1, v); chk("R11 turn up", v, 1);
    @(negedge clk); rd(1, v); chk("R11 rising", v, 2);

    // R13 wrap PWM mode 10
    wr(0, 8'b0110_1000); wr(2, 8'd2); wr(1, 8'd254); wr(0, 8'b0110_1001);
    @(negedge clk); rd(1, v); chk("R13 FF", v, 255);
    @(negedge clk); rd(1, v); chk("R13 wrap", v, 0); chk("R13 set at wrap", cmp_out, 1);
    repeat (3) @(negedge clk); rd(1, v);
    chk("R13 no clear", v, 3); chk("R13 clear on match", cmp_out, 0);
    wr(0, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule